// File: doc/BRIEF.md
# Banked Binary-Point Priority Grouping

This block holds the two binary point settings of an interrupt CPU interface that supports a Secure and a Non-secure security state, and turns an interrupt's 8-bit priority into the group priority used to decide preemption. Software reaches the settings through a single register port. Each access carries a Non-secure attribute. A shared-point control input decides whether Non-secure software gets its own setting or an adjusted view of the Secure one.

The group priority is formed by clearing the low bits of the priority, from bit 0 up to and including bit b, where b is the effective binary point. For a group 1 interrupt with the shared-point control clear, b is the Non-secure setting minus one. The Non-secure side has one fewer priority bit, so this keeps both sides aligned. In every other case b is the Secure setting. With the shared-point control set, a Non-secure read returns the Secure setting plus one, capped at 7. A Non-secure write in that mode is dropped without an error.

Top module: `bpr_group_prio`

## Requirements
- R1: After reset the Secure setting holds S_MIN (default 2) and the Non-secure setting holds NS_MIN (default 3).
- R2: A write with acc_ns low loads the Secure setting with wr_data[2:0], raised to S_MIN if smaller. A read with acc_ns low returns the Secure setting on rd_data.
- R3: A write with acc_ns high and cbp_share low loads the Non-secure setting with wr_data[2:0], raised to NS_MIN if smaller. The Secure setting is left as it was.
- R4: With acc_ns high and cbp_share high, rd_data equals the Secure setting plus one, saturating at 7.
- R5: A write with acc_ns high and cbp_share high changes neither setting.
- R6: With acc_ns high and cbp_share low, rd_data returns the Non-secure setting.
- R7: grp_prio equals irq_prio with bits [b:0] cleared, where b is the effective binary point.
- R8: When irq_grp1 is high and cbp_share is low, b is the Non-secure setting minus one.
- R9: When irq_grp1 is low, or cbp_share is high, b is the Secure setting.
- R10: When b is 7, grp_prio is zero whatever the priority.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_ns | input | 1 | Access attribute: 1 means Non-secure |
| wr_en | input | 1 | Write strobe for the binary point register |
| wr_data | input | 8 | Write data; only bits [2:0] are used |
| cbp_share | input | 1 | Shared-point control: Non-secure side uses the Secure setting |
| rd_data | output | 3 | Binary point value seen by the access described by acc_ns |
| irq_prio | input | 8 | Priority of the interrupt being evaluated |
| irq_grp1 | input | 1 | 1 when that interrupt belongs to group 1 |
| grp_prio | output | 8 | Group priority of that interrupt |

## Verification
The assertions assume that the write strobe, attribute and control are held steady around a clock edge. They also assume that the parameter minimums keep the Non-secure setting at 1 or above, which guarantees that subtracting one never wraps. The bench changes every input only midway between rising edges. It drops the write strobe before it samples the read and group outputs. It also keeps the default minimums throughout, so every value that the clamp or the saturation produces is reached from legal writes alone.

// File: rtl/bpr_group_prio.sv
module bpr_group_prio #(
  parameter int PRIO_W  = 8,
  parameter int S_MIN   = 2,
  parameter int NS_MIN  = 3,
  parameter bit HAS_SEC = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       acc_ns,
  input  logic                       wr_en,
  input  logic [7:0]                 wr_data,
  input  logic                       cbp_share,
  output logic [$clog2(PRIO_W)-1:0]  rd_data,
  input  logic [PRIO_W-1:0]          irq_prio,
  input  logic                       irq_grp1,
  output logic [PRIO_W-1:0]          grp_prio
);
  localparam int BP_W = $clog2(PRIO_W);
  localparam logic [BP_W-1:0] BP_MAX = BP_W'(PRIO_W - 1);
  localparam logic [BP_W-1:0] S_FLOOR = BP_W'(S_MIN);
  localparam logic [BP_W-1:0] NS_FLOOR = BP_W'(NS_MIN);

  logic [BP_W-1:0] s_bp, ns_bp;
  logic [BP_W-1:0] wr_lo, wr_s, wr_ns, s_inc, eff_bp;
  logic [BP_W:0]   shift_amt;
  logic [PRIO_W:0] keep_mask;
  logic            ns_path, ns_grp;

  assign ns_path = HAS_SEC && acc_ns;
  assign ns_grp  = HAS_SEC && irq_grp1 && !cbp_share;
  assign wr_lo   = wr_data[BP_W-1:0];
  assign wr_s    = (wr_lo < S_FLOOR)  ? S_FLOOR  : wr_lo;
  assign wr_ns   = (wr_lo < NS_FLOOR) ? NS_FLOOR : wr_lo;
  assign s_inc   = (s_bp == BP_MAX) ? BP_MAX : s_bp + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_bp  <= S_FLOOR;
      ns_bp <= NS_FLOOR;
    end else if (wr_en) begin
      if (!ns_path)        s_bp  <= wr_s;
      else if (!cbp_share) ns_bp <= wr_ns;
    end
  end

  assign rd_data = !ns_path ? s_bp : (cbp_share ? s_inc : ns_bp);

  assign eff_bp    = ns_grp ? ns_bp - 1'b1 : s_bp;
  assign shift_amt = {1'b0, eff_bp} + 1'b1;
  assign keep_mask = {(PRIO_W+1){1'b1}} << shift_amt;
  assign grp_prio  = irq_prio & keep_mask[PRIO_W-1:0];
endmodule

// File: rtl/bpr_group_prio_chk.sv
module bpr_group_prio_chk #(
  parameter int PRIO_W  = 8,
  parameter int S_MIN   = 2,
  parameter int NS_MIN  = 3,
  parameter bit HAS_SEC = 1'b1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      acc_ns,
  input logic                      wr_en,
  input logic [7:0]                wr_data,
  input logic                      cbp_share,
  input logic [$clog2(PRIO_W)-1:0] rd_data,
  input logic [PRIO_W-1:0]         irq_prio,
  input logic                      irq_grp1,
  input logic [PRIO_W-1:0]         grp_prio,
  input logic [$clog2(PRIO_W)-1:0] s_bp,
  input logic [$clog2(PRIO_W)-1:0] ns_bp
);
  localparam int BP_W = $clog2(PRIO_W);

  p_floor_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (s_bp >= BP_W'(S_MIN)) && (ns_bp >= BP_W'(NS_MIN)));

  p_ignored_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && acc_ns && cbp_share && HAS_SEC) |=> ($stable(s_bp) && $stable(ns_bp)));

  p_ns_write_keeps_s_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && acc_ns && HAS_SEC) |=> $stable(s_bp));

  p_shared_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ns && cbp_share && HAS_SEC) |-> (rd_data >= s_bp && rd_data != '0));

  p_grp_subset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((grp_prio & ~irq_prio) == '0) && !grp_prio[0]);

  p_top_point_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_grp1 && s_bp == BP_W'(PRIO_W - 1)) |-> grp_prio == '0);

  p_wr_unused_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !acc_ns && wr_data[2:0] >= 3'(S_MIN)) |=> s_bp == $past(wr_data[BP_W-1:0]));
endmodule

bind bpr_group_prio bpr_group_prio_chk #(
  .PRIO_W(PRIO_W), .S_MIN(S_MIN), .NS_MIN(NS_MIN), .HAS_SEC(HAS_SEC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_ns(acc_ns), .wr_en(wr_en), .wr_data(wr_data),
  .cbp_share(cbp_share), .rd_data(rd_data), .irq_prio(irq_prio),
  .irq_grp1(irq_grp1), .grp_prio(grp_prio), .s_bp(s_bp), .ns_bp(ns_bp)
);

// File: tb/bpr_group_prio_bench.sv
module bpr_group_prio_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_ns = 1'b0, wr_en = 1'b0, cbp_share = 1'b0, irq_grp1 = 1'b0;
  logic [7:0] wr_data = '0, irq_prio = '0;
  logic [2:0] rd_data;
  logic [7:0] grp_prio;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bpr_group_prio u_bpr_group_prio (
    .clk(clk), .rst_n(rst_n), .acc_ns(acc_ns), .wr_en(wr_en), .wr_data(wr_data),
    .cbp_share(cbp_share), .rd_data(rd_data), .irq_prio(irq_prio),
    .irq_grp1(irq_grp1), .grp_prio(grp_prio)
  );

  typedef struct packed {
    logic [3:0] req;
    logic       ctl;
    logic       ns;
    logic       we;
    logic [7:0] wd;
    logic       g1;
    logic [7:0] prio;
    logic [2:0] rd;
    logic [7:0] gp;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{4'd1,  1'b0,1'b0,1'b0,8'h00,1'b0,8'hFF,3'd2,8'hF8}, // R1 secure reset view
    '{4'd8,  1'b0,1'b1,1'b0,8'h00,1'b1,8'hFF,3'd3,8'hF8}, // R1 R6 R8
    '{4'd7,  1'b0,1'b0,1'b1,8'h0C,1'b0,8'hB7,3'd4,8'hA0}, // R2 R7
    '{4'd2,  1'b0,1'b0,1'b1,8'h01,1'b0,8'h5D,3'd2,8'h58}, // R2 clamp
    '{4'd3,  1'b0,1'b1,1'b1,8'h06,1'b1,8'hFF,3'd6,8'hC0}, // R3 R8
    '{4'd3,  1'b0,1'b1,1'b1,8'h02,1'b1,8'h9E,3'd3,8'h98}, // R3 clamp
    '{4'd3,  1'b0,1'b0,1'b0,8'h00,1'b1,8'h9E,3'd2,8'h98}, // R3 secure untouched
    '{4'd9,  1'b1,1'b0,1'b1,8'h05,1'b1,8'hFF,3'd5,8'hC0}, // R9 shared uses secure
    '{4'd4,  1'b1,1'b1,1'b0,8'h00,1'b1,8'hFF,3'd6,8'hC0}, // R4 plus one
    '{4'd5,  1'b1,1'b1,1'b1,8'h07,1'b1,8'hFF,3'd6,8'hC0}, // R5 write dropped
    '{4'd5,  1'b0,1'b1,1'b0,8'h00,1'b1,8'hFF,3'd3,8'hF8}, // R5 NS setting intact
    '{4'd10, 1'b0,1'b0,1'b1,8'h07,1'b0,8'hFF,3'd7,8'h00}, // R10
    '{4'd4,  1'b1,1'b1,1'b0,8'h00,1'b1,8'hFF,3'd7,8'h00}, // R4 saturation
    '{4'd8,  1'b0,1'b1,1'b1,8'hFF,1'b1,8'hFF,3'd7,8'h80}, // R8 top NS value
    '{4'd9,  1'b0,1'b0,1'b0,8'h00,1'b0,8'h7F,3'd7,8'h00}  // R9 group 0
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    cbp_share = v.ctl; acc_ns = v.ns; wr_en = v.we; wr_data = v.wd;
    irq_grp1 = v.g1; irq_prio = v.prio;
    @(posedge clk);
    #1 wr_en = 1'b0;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      chk($sformatf("R%0d rd vec%0d", VEC[i].req, i), {5'b0, rd_data}, {5'b0, VEC[i].rd});
      chk($sformatf("R%0d gp vec%0d", VEC[i].req, i), grp_prio, VEC[i].gp);
    end
    // R1: reset mid-run restores both minimums
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    acc_ns = 1'b0; cbp_share = 1'b0; #1;
    chk("R1 secure after reset", {5'b0, rd_data}, 8'd2);
    acc_ns = 1'b1; #1;
    chk("R1 nonsecure after reset", {5'b0, rd_data}, 8'd3);
    // R5: shared-mode write then both views unchanged
    apply('{4'd5, 1'b1, 1'b1, 1'b1, 8'h00, 1'b0, 8'hFF, 3'd0, 8'h00});
    chk("R5 shared view", {5'b0, rd_data}, 8'd3);
    cbp_share = 1'b0; #1;
    chk("R5 nonsecure kept", {5'b0, rd_data}, 8'd3);
    acc_ns = 1'b0; #1;
    chk("R5 secure kept", {5'b0, rd_data}, 8'd2);
    finish_run();
  end

  initial begin
    repeat (10000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end
endmodule